// File: doc/BRIEF.md
# Converter Output Conditioning Pipeline

This block sits between a 12-bit sampling converter and its output drivers and handles one sample per clock. Samples use offset-binary coding, so mid-scale is code 2048. Two independent paths run side by side on each registered sample.

The data path adds a signed trim value to the sample and clamps the sum to the code range. A pattern selector can instead replace the outgoing word with a fixed or generated test word. The over-range path raises a flag for samples that are too large. In its default mode the flag is raised only for samples sitting on a rail, and it comes out after a long, fixed delay. In the quick mode the delay is short, and the flag is raised when the sample's distance from mid-scale reaches one of eight programmable levels below full scale.

All configuration comes in as plain register-style inputs. Configuration is captured together with the sample presented in the same cycle, so it applies from that sample onward.

Top module: `adc_cond_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `data_o` is 0 and `ovr_o` is 0.
- R2: With `pat_sel_i` = 000 and `offset_i` = 0, `data_o` equals the sample presented two clocks earlier. The configuration presented alongside a sample is the configuration applied to that sample.
- R3: With `pat_sel_i` = 000, `data_o` is the sample plus `offset_i` read as two's complement (-32 to +31). The result is clamped to 0 below and to 4095 above.
- R4: Select 001 outputs 0x000, select 010 outputs 0xFFF and select 011 outputs 0x800.
- R5: Select 100 outputs alternating words. The first word after the select takes the value 100 is 0xAAA, and each following word is the bitwise inverse of the one before it.
- R6: Select 101 outputs the 12-bit `pat_user_i` word that was presented with the sample.
- R7: Select codes 110 and 111 behave exactly like 000, including the offset.
- R8: While any of the selects 001 to 101 is active, `data_o` depends on neither the sample value nor `offset_i`.
- R9: With `fast_ovr_i` = 0, `ovr_o` is raised for a sample equal to 0 or 4095 and for no other sample. The flag appears 14 clocks after that sample is presented.
- R10: With `fast_ovr_i` = 1, `ovr_o` appears 4 clocks after the sample. It is raised when |sample - 2048| is at or above a level chosen by `fast_lvl_i`. The level for a code with a dB value is 2048 × 10^(-dB/20), rounded to the nearest multiple of 64. The dB values are 20.56, 16.12, 11.02, 7.82, 5.49, 3.66, 2.14 and 0.86 for codes 0 to 7, giving 192, 320, 576, 832, 1088, 1344, 1600 and 1856.
- R11: When `fast_ovr_i` changes value, no flag from any sample presented before the change ever appears on `ovr_o`.
- R12: The over-range path judges the raw sample, whatever the offset and pattern settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| sample_i | input | 12 | Converter sample, offset binary |
| offset_i | input | 6 | Signed output trim |
| pat_sel_i | input | 3 | Test word select |
| pat_user_i | input | 12 | User test word |
| fast_ovr_i | input | 1 | Selects the quick over-range mode |
| fast_lvl_i | input | 3 | Quick-mode threshold code |
| data_o | output | 12 | Conditioned output word |
| ovr_o | output | 1 | Over-range flag |

## Verification
The hardest case to reach is a mode switch while flags from the old mode are still in flight. If a stale flag leaked out, it would look like a correct flag that simply arrived late. The stimulus therefore presents a rail sample in the slow mode and switches to the quick mode on the very next sample, feeding only mid-scale samples afterwards. It then does the reverse with a far-out sample in the quick mode. A cycle-level model in the bench tracks the latency of each sample and the index of the last mode change. It expects the flag to stay low over the whole window in which the stale flag would otherwise have emerged.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;

    // test word select codes
    localparam int PAT_OFF   = 0;
    localparam int PAT_ZERO  = 1;
    localparam int PAT_ONES  = 2;
    localparam int PAT_MID   = 3;
    localparam int PAT_CHECK = 4;
    localparam int PAT_USER  = 5;

    // quick-mode thresholds as multiples of 64 at 12 bits:
    // round(2048 * 10^(-dB/20) / 64) for each programmable level
    function automatic logic [4:0] lvl_mult(input logic [2:0] code);
        logic [4:0] m;
        case (code)
            3'd0:    m = 5'd3;
            3'd1:    m = 5'd5;
            3'd2:    m = 5'd9;
            3'd3:    m = 5'd13;
            3'd4:    m = 5'd17;
            3'd5:    m = 5'd21;
            3'd6:    m = 5'd25;
            default: m = 5'd29;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/adc_cond_data.sv
module adc_cond_data #(
    parameter int DATA_W = 12,
    parameter int OFS_W  = 6,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] user_i,
    output logic [DATA_W-1:0] data_o
);
    import adc_cond_pkg::*;

    localparam int SUM_W = DATA_W + 2;
    localparam logic [DATA_W-1:0] FULL_CODE = '1;
    localparam logic [DATA_W-1:0] MID_CODE  = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic logic [DATA_W-1:0] stripe_word();
        logic [DATA_W-1:0] w;
        for (int i = 0; i < DATA_W; i++) w[i] = (i % 2) == 1;
        return w;
    endfunction

    localparam logic [DATA_W-1:0] STRIPE_A = stripe_word();

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              phase;
    } dp_t;

    dp_t r_d, r_q;
    logic signed [SUM_W-1:0] ofs_ext_d;
    logic signed [SUM_W-1:0] sum_d;
    logic [DATA_W-1:0]       trimmed_d;

    always_comb begin
        ofs_ext_d = {{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
        sum_d     = $signed({2'b00, sample_i}) + ofs_ext_d;
        if (sum_d[SUM_W-1])
            trimmed_d = '0;
        else if (sum_d[SUM_W-2:DATA_W] != '0)
            trimmed_d = FULL_CODE;
        else
            trimmed_d = sum_d[DATA_W-1:0];

        r_d.word  = trimmed_d;
        r_d.phase = 1'b0;
        case (sel_i)
            SEL_W'(PAT_ZERO):  r_d.word = '0;
            SEL_W'(PAT_ONES):  r_d.word = FULL_CODE;
            SEL_W'(PAT_MID):   r_d.word = MID_CODE;
            SEL_W'(PAT_CHECK): begin
                r_d.word  = r_q.phase ? ~STRIPE_A : STRIPE_A;
                r_d.phase = ~r_q.phase;
            end
            SEL_W'(PAT_USER):  r_d.word = user_i;
            default:           r_d.word = trimmed_d;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_o = r_q.word;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_W'(PAT_OFF) && ofs_i == '0) |=> (data_o == $past(sample_i))); // R2
    AST_USER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_W'(PAT_USER)) |=> (data_o == $past(user_i))); // R6
    AST_STRIPE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_W'(PAT_CHECK) && $past(sel_i) == SEL_W'(PAT_CHECK))
        |=> (data_o == ~$past(data_o))); // R5

endmodule

// File: rtl/adc_cond_ovr.sv
module adc_cond_ovr #(
    parameter int DATA_W   = 12,
    parameter int LVL_W    = 3,
    parameter int SLOW_LAT = 14,
    parameter int FAST_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              fast_i,
    input  logic [LVL_W-1:0]  lvl_i,
    output logic              ovr_o
);
    import adc_cond_pkg::*;

    // one input register sits in front, so the line holds LAT-1 stages
    localparam int LINE_D = SLOW_LAT - 1;
    localparam int SLOW_TAP = SLOW_LAT - 2;
    localparam int FAST_TAP = FAST_LAT - 2;
    localparam logic [DATA_W-1:0] MID_CODE  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] FULL_CODE = '1;

    typedef struct packed {
        logic [LINE_D-1:0] line;
        logic              mode;
    } ov_t;

    ov_t o_d, o_q;
    logic [DATA_W-1:0] dev_d;
    logic [DATA_W-1:0] lvl_d;
    logic              hit_d;
    logic              flush_d;

    always_comb begin
        dev_d   = (sample_i >= MID_CODE) ? (sample_i - MID_CODE) : (MID_CODE - sample_i);
        lvl_d   = DATA_W'(lvl_mult(3'(lvl_i))) << (DATA_W - 6);
        hit_d   = fast_i ? (dev_d >= lvl_d)
                         : (sample_i == '0 || sample_i == FULL_CODE);
        flush_d = fast_i != o_q.mode;
        o_d.mode = fast_i;
        if (flush_d)
            o_d.line = {{(LINE_D-1){1'b0}}, hit_d};
        else
            o_d.line = {o_q.line[LINE_D-2:0], hit_d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign ovr_o = o_q.mode ? o_q.line[FAST_TAP] : o_q.line[SLOW_TAP];

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (o_q.mode != $past(o_q.mode)) |-> !ovr_o); // R11
    AST_SLOW_RAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!o_q.mode && $past(!o_q.mode) && ovr_o) |-> $past(o_q.line[SLOW_TAP-1])); // R9

endmodule

// File: rtl/adc_cond_top.sv
module adc_cond_top #(
    parameter int DATA_W   = 12,
    parameter int OFS_W    = 6,
    parameter int SEL_W    = 3,
    parameter int LVL_W    = 3,
    parameter int SLOW_LAT = 14,
    parameter int FAST_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [SEL_W-1:0]  pat_sel_i,
    input  logic [DATA_W-1:0] pat_user_i,
    input  logic              fast_ovr_i,
    input  logic [LVL_W-1:0]  fast_lvl_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ovr_o
);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    // sample and its configuration are captured on the same edge
    typedef struct packed {
        logic [DATA_W-1:0] sample;
        logic [OFS_W-1:0]  ofs;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] user;
        logic              fast;
        logic [LVL_W-1:0]  lvl;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d.sample = sample_i;
        c_d.ofs    = offset_i;
        c_d.sel    = pat_sel_i;
        c_d.user   = pat_user_i;
        c_d.fast   = fast_ovr_i;
        c_d.lvl    = fast_lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.sample <= MID_CODE;
        end else begin
            c_q <= c_d;
        end
    end

    adc_cond_data #(.DATA_W(DATA_W), .OFS_W(OFS_W), .SEL_W(SEL_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (c_q.sample),
        .ofs_i    (c_q.ofs),
        .sel_i    (c_q.sel),
        .user_i   (c_q.user),
        .data_o   (data_o)
    );

    adc_cond_ovr #(.DATA_W(DATA_W), .LVL_W(LVL_W), .SLOW_LAT(SLOW_LAT),
                   .FAST_LAT(FAST_LAT)) u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (c_q.sample),
        .fast_i   (c_q.fast),
        .lvl_i    (c_q.lvl),
        .ovr_o    (ovr_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (data_o == '0 && !ovr_o)); // R1

endmodule

// File: tb/adc_cond_top_tb.sv
module adc_cond_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sample_i = 12'h800;
    logic [5:0]  offset_i = '0;
    logic [2:0]  pat_sel_i = '0;
    logic [11:0] pat_user_i = '0;
    logic        fast_ovr_i = 1'b0;
    logic [2:0]  fast_lvl_i = '0;
    logic [11:0] data_o;
    logic        ovr_o;

    adc_cond_top u_dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .offset_i(offset_i),
        .pat_sel_i(pat_sel_i), .pat_user_i(pat_user_i), .fast_ovr_i(fast_ovr_i),
        .fast_lvl_i(fast_lvl_i), .data_o(data_o), .ovr_o(ovr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          due;
        logic [11:0] word;
        string       req;
    } item_t;

    item_t exp_q[$];
    bit    fast_hist [MAXC];
    bit    flag_hist [MAXC];
    int    tog_last  [MAXC];
    int    cyc = 0;
    int    start_idx = 0;
    bit    running = 1'b0;
    bit    stripe_ph = 1'b0;
    int    n_checks = 0;
    int    n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
        end
    endtask

    function automatic int level_of(int code);
        real db;
        real x;
        case (code)
            0: db = 20.56;  1: db = 16.12;  2: db = 11.02;  3: db = 7.82;
            4: db = 5.49;   5: db = 3.66;   6: db = 2.14;   default: db = 0.86;
        endcase
        x = 2048.0 * $pow(10.0, -db / 20.0);
        return $rtoi(x / 64.0 + 0.5) * 64;
    endfunction

    // driver: presents one sample and pushes what the requirements predict
    task automatic drive(int s, int ofs, int sel, int user, bit fast, int lvl);
        int n;
        int w;
        int dev;
        string req;
        @(posedge clk);
        #1;
        sample_i   = 12'(s);
        offset_i   = 6'(ofs);
        pat_sel_i  = 3'(sel);
        pat_user_i = 12'(user);
        fast_ovr_i = fast;
        fast_lvl_i = 3'(lvl);
        n = cyc;
        case (sel)
            1: begin w = 0;     req = "R4"; end
            2: begin w = 4095;  req = "R4"; end
            3: begin w = 2048;  req = "R4"; end
            4: begin w = stripe_ph ? 12'h555 : 12'hAAA; req = "R5"; end
            5: begin w = user;  req = "R6"; end
            default: begin
                w = s + ofs;
                if (w < 0) w = 0;
                if (w > 4095) w = 4095;
                req = (sel == 0) ? ((ofs == 0) ? "R2" : "R3") : "R7";
            end
        endcase
        stripe_ph = (sel == 4) ? !stripe_ph : 1'b0;
        exp_q.push_back('{due: n + 2, word: 12'(w), req: req});
        dev = (s >= 2048) ? s - 2048 : 2048 - s;
        fast_hist[n] = fast;
        flag_hist[n] = fast ? (dev >= level_of(lvl)) : (s == 0 || s == 4095);
        if (fast != ((n > 0) ? fast_hist[n-1] : 1'b0)) tog_last[n] = n;
        else tog_last[n] = (n > 0) ? tog_last[n-1] : 0;
    endtask

    // monitor: pops the scoreboard and checks the flag model
    always @(negedge clk) begin
        if (running && cyc >= start_idx + 2) begin
            int k;
            int lat;
            int s;
            bit m;
            bit expf;
            string req;
            k = cyc;
            while (exp_q.size() > 0 && exp_q[0].due < k) void'(exp_q.pop_front());
            if (exp_q.size() > 0 && exp_q[0].due == k) begin
                item_t it;
                it = exp_q.pop_front();
                check(it.req, data_o, it.word);
            end
            m   = fast_hist[k-2];
            lat = m ? 4 : 14;
            s   = k - lat;
            if (s >= 0 && s < tog_last[k-2]) begin
                expf = 1'b0;
                req  = "R11";
            end else begin
                expf = (s >= 0) ? flag_hist[s] : 1'b0;
                req  = m ? "R10" : "R9";
            end
            check(req, ovr_o, expf);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", data_o, 0);
        check("R1", ovr_o, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", data_o, 0);
        check("R1", ovr_o, 0);
        start_idx = cyc + 1;
        running = 1'b1;

        // R2 R9: plain passthrough, rails and near-rails in slow mode
        drive(100, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0);
        drive(4095, 0, 0, 0, 0, 0);
        drive(4094, 0, 0, 0, 0, 0);
        drive(2048, 0, 0, 0, 0, 0);
        drive(3000, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) drive(2048 + i * 7, 0, 0, 0, 0, 0);

        // R3: trims and clamping at both ends; R12 rail flag despite offset
        drive(4080, 31, 0, 0, 0, 0);
        drive(4064, 31, 0, 0, 0, 0);
        drive(4000, 31, 0, 0, 0, 0);
        drive(10, -32, 0, 0, 0, 0);
        drive(32, -32, 0, 0, 0, 0);
        drive(100, -32, 0, 0, 0, 0);
        drive(0, -1, 0, 0, 0, 0);
        drive(4095, -1, 0, 0, 0, 0);
        drive(0, 5, 0, 0, 0, 0);

        // R4 R5 R6 R8 R12: test words over varying samples and trims
        for (int sel = 1; sel <= 5; sel++)
            for (int i = 0; i < 5; i++)
                drive((i * 1021) % 4096, i * 9 - 20, sel, 12'h3C5 + i, 0, 0);
        drive(0, 0, 4, 0, 0, 0);
        drive(4095, 0, 4, 0, 0, 0);
        drive(7, 0, 5, 12'hABC, 0, 0);
        drive(9, 0, 4, 0, 0, 0);
        drive(9, 0, 4, 0, 0, 0);

        // R7: unsupported selects act as normal with trim
        drive(1000, 5, 6, 12'hFFF, 0, 0);
        drive(4093, 7, 7, 0, 0, 0);
        drive(3, -9, 6, 0, 0, 0);

        // R10: each quick level, at and just inside the threshold, both sides
        for (int c = 0; c < 8; c++) begin
            int t;
            t = level_of(c);
            drive(2048 + t, 0, 0, 0, 1, c);
            drive(2048 + t - 1, 0, 0, 0, 1, c);
            drive(2048 - t, 0, 0, 0, 1, c);
            drive(2048 - t + 1, 0, 0, 0, 1, c);
        end
        for (int i = 0; i < 6; i++) drive(2048, 0, 0, 0, 1, 0);

        // R11: rail sample in slow mode, then switch to quick immediately
        for (int i = 0; i < 16; i++) drive(2048, 0, 0, 0, 0, 0);
        drive(4095, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) drive(2048, 0, 0, 0, 1, 7);
        // far sample in quick mode, then back to slow
        drive(4000, 0, 0, 0, 1, 0);
        for (int i = 0; i < 20; i++) drive(2048, 0, 0, 0, 0, 0);

        for (int i = 0; i < 20; i++) drive(2048, 0, 0, 0, 0, 0);
        running = 1'b0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule